// File: doc/BRIEF.md
# Single-Level Page-Table Address Translator

This block turns 32-bit device virtual addresses into 36-bit physical bus addresses. It uses one flat page table that lives in memory. Pages are 4 KB. Each table entry is 32 bits wide and holds a 24-bit frame number and three flags: valid, writeable and 1 MB superpage. The table base and the scratch page are given as frame numbers, which are physical addresses shifted right by 12. An eight-entry fully associative TLB holds recent entries. A miss reads one entry through a simple memory read port, at the table base plus four times the virtual page number. A superpage entry is cached once and then covers its whole 1 MB region.

There are three fault classes: invalid entry, write to a read-only page, and virtual page beyond the table limit. Each class has its own abort enable and its own interrupt enable. An aborted request gets an error response and no address. An access to an invalid entry can instead be redirected to a scratch page. Software can ask for the whole TLB to be invalidated. The block reports busy until the invalidation is finished and accepts no new request in that time.

Requests enter on a valid/ready stream and leave on a valid/ready stream. Only one request is in flight at a time. The request side is ready only when the block is idle and no clear is pending or running. A response stays on the port, unchanged, until the consumer takes it. A table read request likewise holds its address until the memory accepts it. Configuration, clear and fault status pins are plain levels.

Top module: `mmu_xlate`

## Requirements
- R1: When `cfg_xlate_en` is 0, a request returns `rsp_pa` equal to the virtual address zero-extended to 36 bits, with `rsp_err` 0 and no table read.
- R2: On a TLB miss, the block reads the entry at `{cfg_tbl_frame, 12'h000} + 4*VPN`, where VPN = va[31:12]. For an ordinary entry the response is `{entry[23:0], va[11:0]}`.
- R3: An entry with bit 28 set is cached in the TLB. A later request to the same 4 KB page is answered with no table read.
- R4: An entry with bit 31 set is a 1 MB superpage whose physical region is 1 MB aligned. The response is `{entry[23:8], va[19:0]}`, and any page in the same 1 MB virtual region then hits without a table read.
- R5: With `cfg_inv_check` 1, an entry with bit 28 clear (including all zeros) is an invalid-entry fault. With `cfg_inv_abort` 1 and the scratch redirect off, the response has `rsp_err` 1 and `rsp_pa` 0.
- R6: With `cfg_scr_en` 1, an invalid-entry fault responds `{cfg_scr_frame, va[11:0]}` with `rsp_err` 0. This redirect takes precedence over abort.
- R7: A write request to an entry with bit 29 clear is a write fault. It returns an error when `cfg_wr_abort` is 1 and translates normally when it is 0. Read requests to such a page translate normally.
- R8: A request whose VPN is at or above `cfg_tbl_pages` is a capacity fault and makes no table read. With `cfg_cap_abort` 1 it returns an error.
- R9: `flt_status` bit 0 records invalid-entry faults, bit 1 write faults and bit 2 capacity faults. A bit is set only when the interrupt enable for its class is 1. `flt_irq` is the OR of the three bits. `flt_va` latches the virtual address of the last recorded fault. Writing 1 to a bit of `flt_clr` clears that bit.
- R10: A one-cycle `clr_req` pulse seen while idle keeps `clr_busy` high for 8 cycles, with `req_ready` low. It invalidates every TLB entry and resets replacement to slot 0. Afterwards, previously cached pages are fetched again.
- R11: A request is taken when `req_valid` and `req_ready` are both 1. `rsp_valid`, `rsp_pa` and `rsp_err` hold until `rsp_ready`. `mem_rd_valid` and `mem_rd_addr` hold until `mem_rd_ready`.
- R12: TLB fills replace slots in round-robin order. The ninth distinct page after a clear evicts the first, while the second stays cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_xlate_en | input | 1 | Translation enable; 0 passes addresses through |
| cfg_tbl_frame | input | 24 | Page table base frame number |
| cfg_tbl_pages | input | 21 | Number of table entries; VPNs at or above it are capacity faults |
| cfg_inv_check | input | 1 | Treat entries with the valid flag clear as faults |
| cfg_inv_abort | input | 1 | Abort on invalid-entry fault |
| cfg_inv_irq | input | 1 | Record invalid-entry faults in status |
| cfg_wr_abort | input | 1 | Abort on write fault |
| cfg_wr_irq | input | 1 | Record write faults in status |
| cfg_cap_abort | input | 1 | Abort on capacity fault |
| cfg_cap_irq | input | 1 | Record capacity faults in status |
| cfg_scr_en | input | 1 | Redirect invalid accesses to the scratch page |
| cfg_scr_frame | input | 24 | Scratch page frame number |
| clr_req | input | 1 | Pulse to invalidate the whole TLB |
| clr_busy | output | 1 | High while a TLB clear is pending or running |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 36 | Physical address (0 on error) |
| rsp_err | output | 1 | Request aborted by a fault |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 36 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data valid for one cycle |
| mem_rsp_data | input | 32 | Entry data |
| flt_status | output | 3 | Sticky fault flags {capacity, write, invalid} |
| flt_clr | input | 3 | Write-1-to-clear for the fault flags |
| flt_va | output | 32 | Virtual address of the last recorded fault |
| flt_irq | output | 1 | Level interrupt, OR of the fault flags |

## Verification
The assertions check the following on every cycle:
- Responses and table reads hold their values while stalled.
- An error response carries address zero.
- No request is accepted while a clear is busy, and no table read happens with translation off.
- The TLB never matches two slots at once and is never filled during a clear.
- A finished clear leaves no valid slot.
- A fault flag rises only after a matching fault event.

Only the directed scenarios can show the following, because each depends on the order of many requests:
- The translated addresses themselves.
- That cached and superpage hits avoid table reads.
- The order of fault handling: scratch redirect ahead of abort, and the capacity limit checked before any read.
- That round-robin eviction picks the expected victim.
- That a clear forces pages to be fetched again.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int PTE_SUPER_BIT = 31;
  localparam int PTE_WR_BIT    = 29;
  localparam int PTE_VALID_BIT = 28;

  localparam int FLT_INV = 0;
  localparam int FLT_WR  = 1;
  localparam int FLT_CAP = 2;
  localparam int NUM_FLT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xl_state_e;
endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
  parameter int DEPTH   = 8,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 24,
  parameter int SUPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [FRAME_W-1:0] hit_frame,
  output logic               hit_wr,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_sup,
  input  logic               fill_wr,
  input  logic               clr_start,
  output logic               clearing
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0]   v_q, sup_q, wr_q;
  logic [VPN_W-1:0]   tag_q   [DEPTH];
  logic [FRAME_W-1:0] frame_q [DEPTH];
  logic [IDX_W-1:0]   rr_q, cidx_q;
  logic               clearing_q;
  logic [DEPTH-1:0]   hit_vec;

  // Per-slot match: superpage slots compare only the 1 MB region bits
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign hit_vec[i] = v_q[i] &&
      (sup_q[i] ? (tag_q[i][VPN_W-1:SUPER_W] == lk_vpn[VPN_W-1:SUPER_W])
                : (tag_q[i] == lk_vpn));
  end

  always_comb begin
    hit_frame = '0;
    hit_wr    = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) begin
        hit_frame = hit_frame | (sup_q[i] ?
          {frame_q[i][FRAME_W-1:SUPER_W], lk_vpn[SUPER_W-1:0]} : frame_q[i]);
        hit_wr = hit_wr | wr_q[i];
      end
    end
  end
  assign hit      = |hit_vec;
  assign clearing = clearing_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q        <= '0;
      sup_q      <= '0;
      wr_q       <= '0;
      rr_q       <= '0;
      cidx_q     <= '0;
      clearing_q <= 1'b0;
    end else if (clr_start) begin
      clearing_q <= 1'b1;
      cidx_q     <= '0;
      rr_q       <= '0;
    end else if (clearing_q) begin
      v_q[cidx_q] <= 1'b0;
      if (cidx_q == LAST) clearing_q <= 1'b0;
      else                cidx_q     <= cidx_q + 1'b1;
    end else if (fill_en) begin
      v_q[rr_q]   <= 1'b1;
      sup_q[rr_q] <= fill_sup;
      wr_q[rr_q]  <= fill_wr;
      rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !clearing_q && !clr_start) begin
      tag_q[rr_q]   <= fill_vpn;
      frame_q[rr_q] <= fill_frame;
    end
  end

  p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_no_fill_in_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clearing_q |-> !fill_en);
  p_all_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearing_q) |-> (v_q == '0));
endmodule

// File: rtl/mmu_fault.sv
module mmu_fault #(
  parameter int NF   = 3,
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   set_i,
  input  logic [VA_W-1:0] set_va_i,
  input  logic [NF-1:0]   clr_i,
  output logic [NF-1:0]   status_o,
  output logic [VA_W-1:0] va_o,
  output logic            irq_o
);
  logic [NF-1:0]   status_q;
  logic [VA_W-1:0] va_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      va_q     <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;
      if (|set_i) va_q <= set_va_i;
    end
  end

  assign status_o = status_q;
  assign va_o     = va_q;
  assign irq_o    = |status_q;

  for (genvar i = 0; i < NF; i++) begin : g_chk
    p_flag_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[i]) |-> $past(set_i[i]));
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> status_q[i]);
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_W    = 12,
  parameter int FRAME_W   = 24,
  parameter int PTE_W     = 32,
  parameter int TLB_DEPTH = 8,
  parameter int SUPER_W   = 8,
  localparam int VPN_W    = VA_W - PAGE_W,
  localparam int PA_W     = FRAME_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_xlate_en,
  input  logic [FRAME_W-1:0] cfg_tbl_frame,
  input  logic [VPN_W:0]     cfg_tbl_pages,
  input  logic               cfg_inv_check,
  input  logic               cfg_inv_abort,
  input  logic               cfg_inv_irq,
  input  logic               cfg_wr_abort,
  input  logic               cfg_wr_irq,
  input  logic               cfg_cap_abort,
  input  logic               cfg_cap_irq,
  input  logic               cfg_scr_en,
  input  logic [FRAME_W-1:0] cfg_scr_frame,
  input  logic               clr_req,
  output logic               clr_busy,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_err,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic [NUM_FLT-1:0] flt_status,
  input  logic [NUM_FLT-1:0] flt_clr,
  output logic [VA_W-1:0]    flt_va,
  output logic               flt_irq
);
  xl_state_e          state_q, state_d;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [PA_W-1:0]    pa_q, pa_d;
  logic               err_q, err_d;
  logic               clr_pend_q;
  logic [NUM_FLT-1:0] flt_set;

  logic [VPN_W-1:0]   vpn;
  logic [PAGE_W-1:0]  off;
  assign vpn = va_q[VA_W-1:PAGE_W];
  assign off = va_q[PAGE_W-1:0];

  // TLB and clear sequencing
  logic               t_hit, t_wr, t_clearing, clr_start, fill_en;
  logic [FRAME_W-1:0] t_frame;

  assign clr_start = (clr_req || clr_pend_q) && (state_q == ST_IDLE) && !t_clearing;
  assign clr_busy  = clr_pend_q || t_clearing;
  assign req_ready = (state_q == ST_IDLE) && !clr_req && !clr_pend_q && !t_clearing;

  // Fetched entry decode
  logic               m_valid, m_wr, m_sup;
  logic [FRAME_W-1:0] m_frame;
  logic               unused_bits;
  assign m_valid = mem_rsp_data[PTE_VALID_BIT];
  assign m_wr    = mem_rsp_data[PTE_WR_BIT];
  assign m_sup   = mem_rsp_data[PTE_SUPER_BIT];
  assign m_frame = m_sup ? {mem_rsp_data[FRAME_W-1:SUPER_W], vpn[SUPER_W-1:0]}
                         : mem_rsp_data[FRAME_W-1:0];
  assign unused_bits = ^{mem_rsp_data[PTE_W-1:FRAME_W]};

  assign fill_en = (state_q == ST_WAIT) && mem_rsp_valid && m_valid;

  mmu_tlb #(
    .DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .FRAME_W(FRAME_W), .SUPER_W(SUPER_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vpn    (vpn),
    .hit       (t_hit),
    .hit_frame (t_frame),
    .hit_wr    (t_wr),
    .fill_en   (fill_en),
    .fill_vpn  (vpn),
    .fill_frame(mem_rsp_data[FRAME_W-1:0]),
    .fill_sup  (m_sup),
    .fill_wr   (m_wr),
    .clr_start (clr_start),
    .clearing  (t_clearing)
  );

  // Entry source: TLB while checking, memory while waiting
  logic               e_valid, e_wr, inv_f, wr_f, cap_f;
  logic [FRAME_W-1:0] e_frame;
  logic [PA_W-1:0]    page_pa, scr_pa;
  assign e_valid = (state_q == ST_WAIT) ? m_valid : 1'b1;
  assign e_wr    = (state_q == ST_WAIT) ? m_wr    : t_wr;
  assign e_frame = (state_q == ST_WAIT) ? m_frame : t_frame;
  assign inv_f   = cfg_inv_check && !e_valid;
  assign wr_f    = !inv_f && wr_q && !e_wr;
  assign cap_f   = {1'b0, vpn} >= cfg_tbl_pages;
  assign page_pa = {e_frame, off};
  assign scr_pa  = {cfg_scr_frame, off};

  assign mem_rd_valid = (state_q == ST_FETCH);
  assign mem_rd_addr  = {cfg_tbl_frame, {PAGE_W{1'b0}}} + PA_W'({vpn, 2'b00});

  // Decision for an entry-based outcome (hit or fetched)
  task automatic decide_entry(output logic [PA_W-1:0] pa, output logic err,
                              output logic [NUM_FLT-1:0] fs);
    pa = page_pa;
    err = 1'b0;
    fs = '0;
    if (inv_f) begin
      fs[FLT_INV] = cfg_inv_irq;
      if (cfg_scr_en)         pa = scr_pa;
      else if (cfg_inv_abort) err = 1'b1;
    end else if (wr_f) begin
      fs[FLT_WR] = cfg_wr_irq;
      if (cfg_wr_abort) err = 1'b1;
    end
    if (err) pa = '0;
  endtask

  always_comb begin
    state_d = state_q;
    pa_d    = pa_q;
    err_d   = err_q;
    flt_set = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid && req_ready) state_d = ST_CHECK;
      ST_CHECK: begin
        state_d = ST_RESP;
        if (!cfg_xlate_en) begin
          pa_d  = PA_W'(va_q);
          err_d = 1'b0;
        end else if (cap_f) begin
          flt_set[FLT_CAP] = cfg_cap_irq;
          err_d = cfg_cap_abort;
          if (cfg_cap_abort)   pa_d = '0;
          else if (cfg_scr_en) pa_d = scr_pa;
          else                 pa_d = {{FRAME_W{1'b0}}, off};
        end else if (t_hit) begin
          decide_entry(pa_d, err_d, flt_set);
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_rd_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) begin
        decide_entry(pa_d, err_d, flt_set);
        state_d = ST_RESP;
      end
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      pa_q       <= '0;
      err_q      <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pa_q    <= pa_d;
      err_q   <= err_d;
      if (req_valid && req_ready) begin
        va_q <= req_va;
        wr_q <= req_write;
      end
      if (clr_start)    clr_pend_q <= 1'b0;
      else if (clr_req) clr_pend_q <= 1'b1;
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_pa    = pa_q;
  assign rsp_err   = err_q;

  mmu_fault #(.NF(NUM_FLT), .VA_W(VA_W)) u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flt_set),
    .set_va_i(va_q),
    .clr_i   (flt_clr),
    .status_o(flt_status),
    .va_o    (flt_va),
    .irq_o   (flt_irq)
  );

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_err));
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_pa == '0);
  p_stall_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !req_ready);
  p_no_fetch_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> cfg_xlate_en);
endmodule

// File: tb/mmu_xlate_tb.sv
module mmu_xlate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_xlate_en = 0, cfg_inv_check = 0, cfg_inv_abort = 0, cfg_inv_irq = 0;
  logic        cfg_wr_abort = 0, cfg_wr_irq = 0, cfg_cap_abort = 0, cfg_cap_irq = 0;
  logic        cfg_scr_en = 0;
  logic [23:0] cfg_tbl_frame = 24'h000100, cfg_scr_frame = '0;
  logic [20:0] cfg_tbl_pages = 21'h100000;
  logic        clr_req = 0, clr_busy;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_va = '0;
  logic        rsp_valid, rsp_ready = 1, rsp_err;
  logic [35:0] rsp_pa;
  logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [35:0] mem_rd_addr;
  logic [31:0] mem_rsp_data;
  logic [2:0]  flt_status, flt_clr = '0;
  logic [31:0] flt_va;
  logic        flt_irq;

  mmu_xlate dut_i (.*);

  int tests = 0, fails = 0, rd_count = 0;
  logic [35:0] last_addr;
  logic [31:0] pt [logic [19:0]];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Table memory model: variable accept stall and return latency
  initial begin
    int pend = 0, stall = 0;
    logic [31:0] pend_data = '0;
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_rsp_valid = 1; mem_rsp_data = pend_data; end
      end
      mem_rd_ready = 0;
      if (mem_rd_valid) begin
        if (stall > 0) stall--;
        else begin
          logic [19:0] k;
          mem_rd_ready = 1;
          rd_count++;
          last_addr = mem_rd_addr;
          k = 20'((mem_rd_addr - {cfg_tbl_frame, 12'h000}) >> 2);
          pend_data = pt.exists(k) ? pt[k] : 32'h0;
          pend = 1 + rd_count % 3;
          stall = rd_count % 3;
        end
      end
    end
  end

  task automatic xlate(input logic [31:0] va, input logic wr,
                       output logic [35:0] pa, output logic err);
    @(negedge clk);
    req_va = va; req_write = wr; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    pa = rsp_pa; err = rsp_err;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset req_ready", req_ready, 1);
    chk("R11 reset rsp_valid", rsp_valid, 0);
    chk("R9 reset irq", flt_irq, 0);
    chk("R10 reset busy", clr_busy, 0);
  endtask

  task automatic t_bypass_r1();
    logic [35:0] pa; logic e; int r0 = rd_count;
    xlate(32'hDEADB123, 0, pa, e);
    chk("R1 bypass pa", pa, 36'h0DEADB123);
    chk("R1 bypass err", e, 0);
    chk("R1 bypass no read", rd_count - r0, 0);
  endtask

  task automatic t_miss_hit_r2_r3();
    logic [35:0] pa; logic e; int r0;
    pt[20'h12345] = 32'h300ABCDE;
    r0 = rd_count;
    xlate(32'h12345678, 0, pa, e);
    chk("R2 miss pa", pa, 36'h0ABCDE678);
    chk("R2 entry address", last_addr, 36'h000148D14);
    chk("R2 one read", rd_count - r0, 1);
    xlate(32'h12345FF0, 1, pa, e);
    chk("R3 hit pa", pa, 36'h0ABCDEFF0);
    chk("R3 hit no read", rd_count - r0, 1);
  endtask

  task automatic t_super_r4();
    logic [35:0] pa; logic e; int r0;
    pt[20'h40005] = 32'hB007A005;
    r0 = rd_count;
    xlate(32'h40005123, 0, pa, e);
    chk("R4 super pa", pa, 36'h07A005123);
    xlate(32'h400FF010, 0, pa, e);
    chk("R4 super region pa", pa, 36'h07A0FF010);
    chk("R4 single read", rd_count - r0, 1);
  endtask

  task automatic t_invalid_r5_r6();
    logic [35:0] pa; logic e;
    cfg_inv_check = 1; cfg_inv_abort = 1; cfg_inv_irq = 1;
    xlate(32'h55555000, 0, pa, e);
    chk("R5 invalid err", e, 1);
    chk("R5 invalid pa", pa, 0);
    chk("R9 invalid status", flt_status, 3'b001);
    chk("R9 irq", flt_irq, 1);
    chk("R9 fault va", flt_va, 32'h55555000);
    flt_clr = 3'b001; @(negedge clk); flt_clr = 0;
    chk("R9 w1c", flt_irq, 0);
    cfg_scr_en = 1; cfg_scr_frame = 24'h000ABC;
    xlate(32'h55555123, 0, pa, e);
    chk("R6 scratch pa", pa, 36'h000ABC123);
    chk("R6 scratch over abort", e, 0);
    cfg_scr_en = 0;
    flt_clr = 3'b001; @(negedge clk); flt_clr = 0;
  endtask

  task automatic t_write_r7();
    logic [35:0] pa; logic e;
    pt[20'h22222] = 32'h10011111;
    cfg_wr_abort = 1; cfg_wr_irq = 1;
    xlate(32'h22222ABC, 1, pa, e);
    chk("R7 write abort err", e, 1);
    chk("R9 write status", flt_status, 3'b010);
    xlate(32'h22222ABC, 0, pa, e);
    chk("R7 read ok pa", pa, 36'h011111ABC);
    chk("R7 read ok err", e, 0);
    cfg_wr_abort = 0;
    xlate(32'h22222ABC, 1, pa, e);
    chk("R7 write no abort pa", pa, 36'h011111ABC);
    flt_clr = 3'b010; @(negedge clk); flt_clr = 0;
    cfg_wr_abort = 1; cfg_wr_irq = 0;
    xlate(32'h22222ABC, 1, pa, e);
    chk("R7 write abort hit", e, 1);
    chk("R9 masked no status", flt_status, 3'b000);
  endtask

  task automatic t_cap_r8();
    logic [35:0] pa; logic e; int r0 = rd_count;
    cfg_tbl_pages = 21'h080000; cfg_cap_abort = 1; cfg_cap_irq = 1;
    xlate(32'h90000000, 0, pa, e);
    chk("R8 cap err", e, 1);
    chk("R8 cap no read", rd_count - r0, 0);
    chk("R9 cap status", flt_status, 3'b100);
    chk("R9 cap va", flt_va, 32'h90000000);
    flt_clr = 3'b100; @(negedge clk); flt_clr = 0;
    cfg_tbl_pages = 21'h100000;
  endtask

  task automatic pulse_clear(output int n);
    @(negedge clk);
    clr_req = 1; @(negedge clk); clr_req = 0;
    chk("R10 ready low in clear", req_ready, 0);
    n = 0;
    while (clr_busy) begin n++; @(negedge clk); end
  endtask

  task automatic t_rr_r12();
    logic [35:0] pa; logic e; int n, r0;
    pulse_clear(n);
    for (int i = 0; i < 9; i++) pt[20'h30000 + 20'(i)] = 32'h10060000 + i;
    r0 = rd_count;
    for (int i = 0; i < 9; i++) xlate(32'h30000000 + 32'(i) * 32'h1000, 0, pa, e);
    chk("R12 nine fills", rd_count - r0, 9);
    xlate(32'h30001000, 0, pa, e);
    chk("R12 second kept", rd_count - r0, 9);
    chk("R12 second pa", pa, 36'h060001000);
    xlate(32'h30000000, 0, pa, e);
    chk("R12 first evicted", rd_count - r0, 10);
  endtask

  task automatic t_clear_r10();
    logic [35:0] pa; logic e; int n, r0;
    pt[20'h30002] = 32'h10070002;
    pulse_clear(n);
    chk("R10 busy cycles", n, 8);
    r0 = rd_count;
    xlate(32'h30002000, 0, pa, e);
    chk("R10 refetch", rd_count - r0, 1);
    chk("R10 new mapping", pa, 36'h070002000);
  endtask

  task automatic t_backpressure_r11();
    logic [35:0] pa0;
    pt[20'h44444] = 32'h30012345;
    rsp_ready = 0;
    @(negedge clk);
    req_va = 32'h44444010; req_write = 0; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    pa0 = rsp_pa;
    chk("R11 stalled pa", pa0, 36'h012345010);
    repeat (3) @(negedge clk);
    chk("R11 held valid", rsp_valid, 1);
    chk("R11 held pa", rsp_pa, pa0);
    rsp_ready = 1; @(negedge clk);
    chk("R11 released", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass_r1();
    cfg_xlate_en = 1;
    t_miss_hit_r2_r3();
    t_super_r4();
    t_invalid_r5_r6();
    t_write_r7();
    t_cap_r8();
    t_rr_r12();
    t_clear_r10();
    t_backpressure_r11();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule